// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block runs on the cycle a processor core takes an exception. From the exception class, the faulting PC, the delay-slot flag and the current status bits, it works out where the handler starts and what return address to keep. It also decides how the status and cause fields change. All of these results are registered. They appear together on the clock edge after the request strobe, and they stay unchanged until the next accepted request.

The handler address is a base plus an offset. The base is a fixed boot-time location when bootstrap vectors are selected. Otherwise it is the exception base input with its low ten bits cleared. The offset depends on the class, on whether the core is already at exception level, on the TLB no-match flag, and, for interrupts, on a vector number. The vector number comes either from the highest unmasked pending line or directly from an external interrupt controller. A non-maskable interrupt takes a separate path: it keeps its return address in its own register, raises the error level, and jumps to the reset region.

Top module: `exc_entry_ctrl`

## Requirements
- R1: With BEV clear, the handler base is `exc_base` with bits 9:0 forced to zero. With BEV set, the base is 0xBFC00200.
- R2: The class input is the 5-bit cause code. 0 is interrupt, 1 is modify, 2 is TLB load, 3 is TLB store, 4 and 5 are address error load and store, 8 is syscall, 9 is break, 10 is reserved instruction, 11 is coprocessor unusable, 12 is overflow and 13 is trap. 30 selects cache error and 31 selects non-maskable interrupt. Any class without a special rule, including an interrupt with `irq_vec_en` low, uses offset 0x180.
- R3: Class 2 or 3 with `tlb_nomatch` high and EXL clear uses offset 0x000.
- R4: Class 0 with `irq_vec_en` high uses offset 0x200 when BEV is set or the spacing is zero. Otherwise the offset is 0x200 + vector × (spacing × 32).
- R5: In internal mode (`irq_ext_mode` low), the vector is the index of the highest set bit of `irq_pending & st_im`, or 0 when none is set. In external mode, the vector is `irq_pending` itself.
- R6: When EXL is clear on an accepted non-NMI request, EPC becomes the PC (or PC − 4 in a delay slot), cause BD takes the delay-slot flag, and EXL is set. When EXL is already set, EPC and BD keep their previous values and EXL stays set.
- R7: A non-NMI request writes its class into the cause code and passes ERL and BEV through unchanged. An NMI leaves the cause code unchanged.
- R8: An NMI sets the new PC to 0xBFC00000, saves the resume PC (PC or PC − 4) in ErrorEPC, sets ERL and BEV, and passes EXL through. It clears BD only when EXL is clear, and leaves EPC untouched.
- R9: Class 30 uses offset 0x100 with BEV set and 0x20000100 with BEV clear.
- R10: A request is accepted on a clock edge. All outputs update on that edge, and `entry_taken` is high for exactly the following cycle. A request present while `entry_taken` is high is ignored. With no accepted request, outputs hold.
- R11: After reset, the new PC is 0xBFC00000, and every other output is zero.
- R12: Every handler address produced has bits 4:0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception request strobe |
| exc_class | input | 5 | Exception class / cause code |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_delay_slot | input | 1 | Instruction sits in a branch delay slot |
| tlb_nomatch | input | 1 | TLB lookup found no entry |
| st_exl | input | 1 | Current exception-level bit |
| st_erl | input | 1 | Current error-level bit |
| st_bev | input | 1 | Current bootstrap-vector bit |
| st_im | input | 8 | Interrupt mask |
| irq_vec_en | input | 1 | Vectored interrupts enabled |
| irq_ext_mode | input | 1 | Vector supplied by external controller |
| irq_spacing | input | 5 | Vector spacing in 32-byte units |
| irq_pending | input | 8 | Pending interrupt lines |
| exc_base | input | 32 | Exception base register |
| new_pc | output | 32 | Handler entry address |
| epc | output | 32 | Saved exception return PC |
| error_epc | output | 32 | Saved error return PC |
| out_exl | output | 1 | Updated exception level |
| out_erl | output | 1 | Updated error level |
| out_bev | output | 1 | Updated bootstrap-vector bit |
| cause_code | output | 5 | Updated cause code |
| cause_bd | output | 1 | Updated branch-delay bit |
| entry_taken | output | 1 | One-cycle pulse after an accepted request |

## Verification
The hardest case to reach is the vectored-interrupt address. It needs an interrupt class with vectoring enabled, BEV clear, a nonzero spacing, and a pending/mask pair whose highest common bit picks a particular vector. The stimulus handles this with a nested sweep over every 8-bit pending pattern, both mask patterns, both vector modes and several spacings. A second sweep covers every class against all combinations of EXL, ERL, BEV, delay slot, no-match and vector enable. Its history-dependent results, such as EPC held while already at exception level, are predicted by a running model in the bench. A back-to-back request checks that a strobe arriving during the pulse cycle leaves every output as it was.

// File: rtl/exc_entry_pkg.sv
// Package: shared class codes, fixed addresses and width constants for the
// exception entry controller. Assumes a 32-bit address space.
package exc_entry_pkg;
    localparam int ADDR_W  = 32;
    localparam int CLS_W   = 5;

    localparam logic [CLS_W-1:0] CLS_INT   = 5'd0;
    localparam logic [CLS_W-1:0] CLS_TLBL  = 5'd2;
    localparam logic [CLS_W-1:0] CLS_TLBS  = 5'd3;
    localparam logic [CLS_W-1:0] CLS_CACHE = 5'd30;
    localparam logic [CLS_W-1:0] CLS_NMI   = 5'd31;

    localparam logic [ADDR_W-1:0] BOOT_BASE  = 32'hBFC0_0200;
    localparam logic [ADDR_W-1:0] NMI_PC     = 32'hBFC0_0000;
    localparam logic [ADDR_W-1:0] OFF_GEN    = 32'h0000_0180;
    localparam logic [ADDR_W-1:0] OFF_IRQ    = 32'h0000_0200;
    localparam logic [ADDR_W-1:0] OFF_CACHEB = 32'h0000_0100;
    localparam logic [ADDR_W-1:0] OFF_CACHEN = 32'h2000_0100;
    localparam logic [ADDR_W-1:0] BASE_MASK  = 32'hFFFF_FC00;
endpackage

// File: rtl/exc_irq_vector.sv
// Module: exc_irq_vector
// Produces the interrupt vector number. Internal mode picks the index of the
// highest pending line that is also enabled in the mask (0 when none). External
// mode passes the pending field through as the vector. Purely combinational.
module exc_irq_vector #(
    parameter int IRQ_N = 8
) (
    input  logic [IRQ_N-1:0] pending,
    input  logic [IRQ_N-1:0] mask,
    input  logic             ext_mode,
    output logic [IRQ_N-1:0] vector
);
    localparam int IDX_W = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;

    logic [IRQ_N-1:0] enabled;
    logic [IDX_W-1:0] top_idx;

    // Priority scan: later (higher) indices override earlier ones.
    always_comb begin
        enabled = pending & mask;
        top_idx = '0;
        for (int i = 0; i < IRQ_N; i++) begin
            if (enabled[i]) top_idx = IDX_W'(i);
        end
    end

    // Mode select between scanned index and the raw pending field.
    always_comb begin
        vector = ext_mode ? pending : IRQ_N'(top_idx);
    end
endmodule

// File: rtl/exc_target_sel.sv
// Module: exc_target_sel
// Forms the handler entry address as base plus class-dependent offset.
// Assumes the NMI path is handled by the caller; this module covers all
// vectors that are relative to the handler base.
module exc_target_sel
    import exc_entry_pkg::*;
#(
    parameter int IRQ_N = 8,
    parameter int SPC_W = 5
) (
    input  logic [CLS_W-1:0]  cls,
    input  logic              exl,
    input  logic              bev,
    input  logic              nomatch,
    input  logic              vec_en,
    input  logic [SPC_W-1:0]  spacing,
    input  logic [IRQ_N-1:0]  vector,
    input  logic [ADDR_W-1:0] ebase,
    output logic [ADDR_W-1:0] target
);
    localparam int SPC_SHIFT = 5;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] vec_step;

    // Per-vector distance scaled by the spacing in 32-byte units.
    always_comb begin
        vec_step = ADDR_W'(vector) * (ADDR_W'(spacing) << SPC_SHIFT);
    end

    // Offset selection by class, level and vector mode.
    always_comb begin
        offset = OFF_GEN;
        if (cls == CLS_INT && vec_en) begin
            offset = (bev || spacing == '0) ? OFF_IRQ : OFF_IRQ + vec_step;
        end else if ((cls == CLS_TLBL || cls == CLS_TLBS) && nomatch && !exl) begin
            offset = '0;
        end else if (cls == CLS_CACHE) begin
            offset = bev ? OFF_CACHEB : OFF_CACHEN;
        end
    end

    // Base selection and final sum.
    always_comb begin
        base   = bev ? BOOT_BASE : (ebase & BASE_MASK);
        target = base + offset;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl
// Top of the exception entry controller. Accepts a one-cycle request, and on
// that clock edge registers the handler PC, return PCs and updated status and
// cause fields. Raises entry_taken for the next cycle, during which a new
// request is ignored. Assumes status inputs reflect the state at the request.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int IRQ_N = 8,
    parameter int SPC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CLS_W-1:0]  exc_class,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              in_delay_slot,
    input  logic              tlb_nomatch,
    input  logic              st_exl,
    input  logic              st_erl,
    input  logic              st_bev,
    input  logic [IRQ_N-1:0]  st_im,
    input  logic              irq_vec_en,
    input  logic              irq_ext_mode,
    input  logic [SPC_W-1:0]  irq_spacing,
    input  logic [IRQ_N-1:0]  irq_pending,
    input  logic [ADDR_W-1:0] exc_base,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] epc,
    output logic [ADDR_W-1:0] error_epc,
    output logic              out_exl,
    output logic              out_erl,
    output logic              out_bev,
    output logic [CLS_W-1:0]  cause_code,
    output logic              cause_bd,
    output logic              entry_taken
);
    localparam logic [ADDR_W-1:0] SLOT_BACK = ADDR_W'(4);

    logic [IRQ_N-1:0]  irq_vector;
    logic [ADDR_W-1:0] handler_pc;
    logic [ADDR_W-1:0] resume_pc;
    logic              accept;
    logic              is_nmi;

    exc_irq_vector #(.IRQ_N(IRQ_N)) u_vec (
        .pending  (irq_pending),
        .mask     (st_im),
        .ext_mode (irq_ext_mode),
        .vector   (irq_vector)
    );

    exc_target_sel #(.IRQ_N(IRQ_N), .SPC_W(SPC_W)) u_tgt (
        .cls     (exc_class),
        .exl     (st_exl),
        .bev     (st_bev),
        .nomatch (tlb_nomatch),
        .vec_en  (irq_vec_en),
        .spacing (irq_spacing),
        .vector  (irq_vector),
        .ebase   (exc_base),
        .target  (handler_pc)
    );

    // Request qualification and return address formation.
    always_comb begin
        accept    = exc_req && !entry_taken;
        is_nmi    = (exc_class == CLS_NMI);
        resume_pc = in_delay_slot ? cur_pc - SLOT_BACK : cur_pc;
    end

    // State update on an accepted request; all fields hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc      <= NMI_PC;
            epc         <= '0;
            error_epc   <= '0;
            out_exl     <= 1'b0;
            out_erl     <= 1'b0;
            out_bev     <= 1'b0;
            cause_code  <= '0;
            cause_bd    <= 1'b0;
            entry_taken <= 1'b0;
        end else begin
            entry_taken <= accept;
            if (accept) begin
                if (is_nmi) begin
                    new_pc    <= NMI_PC;
                    error_epc <= resume_pc;
                    out_erl   <= 1'b1;
                    out_bev   <= 1'b1;
                    out_exl   <= st_exl;
                    if (!st_exl) cause_bd <= 1'b0;
                end else begin
                    new_pc     <= handler_pc;
                    out_erl    <= st_erl;
                    out_bev    <= st_bev;
                    out_exl    <= 1'b1;
                    cause_code <= exc_class;
                    if (!st_exl) begin
                        epc      <= resume_pc;
                        cause_bd <= in_delay_slot;
                    end
                end
            end
        end
    end

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_taken |=> !entry_taken);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req || entry_taken) |=> ($stable(new_pc) && $stable(epc) && $stable(cause_code)));

    // R6
    epc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_exl) |=> $stable(epc) && out_exl);

    // R6
    epc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_nmi && !st_exl && in_delay_slot) |=> (epc == $past(cur_pc) - SLOT_BACK) && cause_bd);

    // R8
    nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_nmi) |=> (new_pc == NMI_PC) && out_erl && out_bev && $stable(epc));

    // R12
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_taken |-> (new_pc[4:0] == 5'd0));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EBASE = 32'h8123_4567;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_class = '0;
    logic [31:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0, tlb_nomatch = 1'b0;
    logic        st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0;
    logic [7:0]  st_im = '0;
    logic        irq_vec_en = 1'b0, irq_ext_mode = 1'b0;
    logic [4:0]  irq_spacing = '0;
    logic [7:0]  irq_pending = '0;
    logic [31:0] exc_base = EBASE;
    logic [31:0] new_pc, epc, error_epc;
    logic        out_exl, out_erl, out_bev, cause_bd, entry_taken;
    logic [4:0]  cause_code;

    int vectors = 0;
    int errors = 0;
    bit finished = 0;

    // running expected state
    logic [31:0] m_pc, m_epc, m_eepc;
    logic        m_exl, m_erl, m_bev, m_bd;
    logic [4:0]  m_code;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_class(exc_class),
        .cur_pc(cur_pc), .in_delay_slot(in_delay_slot), .tlb_nomatch(tlb_nomatch),
        .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev), .st_im(st_im),
        .irq_vec_en(irq_vec_en), .irq_ext_mode(irq_ext_mode),
        .irq_spacing(irq_spacing), .irq_pending(irq_pending), .exc_base(exc_base),
        .new_pc(new_pc), .epc(epc), .error_epc(error_epc), .out_exl(out_exl),
        .out_erl(out_erl), .out_bev(out_bev), .cause_code(cause_code),
        .cause_bd(cause_bd), .entry_taken(entry_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] top_bit(input logic [7:0] v);
        logic [31:0] r = 0;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    // model of the handler address for non-NMI classes (R1..R5, R9)
    function automatic logic [31:0] ref_target();
        logic [31:0] base, off, vn;
        base = st_bev ? 32'hBFC0_0200 : {exc_base[31:10], 10'd0};
        off = 32'h180;
        if (exc_class == 0 && irq_vec_en) begin
            vn = irq_ext_mode ? {24'd0, irq_pending} : top_bit(irq_pending & st_im);
            off = (st_bev || irq_spacing == 0) ? 32'h200 : 32'h200 + vn * irq_spacing * 32;
        end else if ((exc_class == 2 || exc_class == 3) && tlb_nomatch && !st_exl) off = 0;
        else if (exc_class == 30) off = st_bev ? 32'h100 : 32'h2000_0100;
        return base + off;
    endfunction

    function automatic string pc_tag();
        if (exc_class == 31) return "R8";
        if (exc_class == 30) return "R9";
        if (exc_class == 0 && irq_vec_en) return irq_spacing == 0 || st_bev ? "R4" : "R5";
        if ((exc_class == 2 || exc_class == 3) && tlb_nomatch && !st_exl) return "R3";
        return st_bev ? "R2" : "R1";
    endfunction

    task automatic update_model();
        logic [31:0] rp = in_delay_slot ? cur_pc - 4 : cur_pc;
        if (exc_class == 31) begin
            m_pc = 32'hBFC0_0000; m_eepc = rp; m_erl = 1; m_bev = 1; m_exl = st_exl;
            if (!st_exl) m_bd = 0;
        end else begin
            m_pc = ref_target(); m_erl = st_erl; m_bev = st_bev; m_exl = 1; m_code = exc_class;
            if (!st_exl) begin m_epc = rp; m_bd = in_delay_slot; end
        end
    endtask

    task automatic check_all(input string tag, input logic exp_taken);
        chk("R10", "entry_taken", {31'd0, entry_taken}, {31'd0, exp_taken});
        chk(tag, "new_pc", new_pc, m_pc);
        chk("R6", "epc", epc, m_epc);
        chk("R8", "error_epc", error_epc, m_eepc);
        chk("R6", "exl", {31'd0, out_exl}, {31'd0, m_exl});
        chk("R7", "erl", {31'd0, out_erl}, {31'd0, m_erl});
        chk("R7", "bev", {31'd0, out_bev}, {31'd0, m_bev});
        chk("R7", "cause_code", {27'd0, cause_code}, {27'd0, m_code});
        chk("R6", "cause_bd", {31'd0, cause_bd}, {31'd0, m_bd});
        chk("R12", "pc_align", {27'd0, new_pc[4:0]}, 32'd0);
    endtask

    // one request: strobe for one cycle, check after the registering edge
    task automatic apply();
        string tag;
        tag = pc_tag();
        exc_req = 1'b1;
        update_model();
        @(negedge clk);
        exc_req = 1'b0;
        vectors++;
        check_all(tag, 1'b1);
        @(negedge clk);
    endtask

    initial begin
        int idx;
        logic [4:0] cls_list [16];
        cls_list = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd8, 5'd9,
                     5'd10, 5'd11, 5'd12, 5'd13, 5'd6, 5'd20, 5'd30, 5'd31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        m_pc = 32'hBFC0_0000; m_epc = 0; m_eepc = 0; m_exl = 0; m_erl = 0;
        m_bev = 0; m_bd = 0; m_code = 0;
        vectors++;
        check_all("R11", 1'b0);

        // class x status sweep (R1 R2 R3 R6 R7 R8 R9)
        idx = 0;
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 64; k++) begin
                exc_class = cls_list[c];
                {st_exl, st_bev, in_delay_slot, tlb_nomatch, irq_vec_en, st_erl} = 6'(k);
                irq_ext_mode = 0; irq_spacing = 5'd3; irq_pending = 8'h24; st_im = 8'hFF;
                cur_pc = 32'h0040_0000 + 32'(idx) * 8;
                idx++;
                apply();
            end
        end

        // vectored interrupt sweep (R4 R5)
        exc_class = 0; irq_vec_en = 1; st_bev = 0; st_exl = 0; st_erl = 0;
        tlb_nomatch = 0; in_delay_slot = 0;
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 4; s++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int p = 0; p < 256; p++) begin
                        irq_ext_mode = e[0];
                        irq_spacing = (s == 0) ? 5'd0 : (s == 1) ? 5'd1 : (s == 2) ? 5'd3 : 5'd31;
                        st_im = m[0] ? 8'h5A : 8'hFF;
                        irq_pending = 8'(p);
                        cur_pc = 32'h0080_0000 + 32'(p) * 4;
                        apply();
                    end
                end
            end
        end

        // R10: request during the pulse cycle is ignored
        exc_class = 5'd9; st_exl = 0; st_bev = 0; in_delay_slot = 0; cur_pc = 32'h0000_1000;
        exc_req = 1'b1;
        update_model();
        @(negedge clk);
        vectors++;
        check_all("R10", 1'b1);
        exc_class = 5'd31; cur_pc = 32'h0000_2000; st_bev = 1;
        @(negedge clk);
        exc_req = 1'b0;
        vectors++;
        check_all("R10", 1'b0);
        @(negedge clk);
        vectors++;
        check_all("R10", 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule